// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves 32-bit words between system memory and up to eight endpoint FIFOs. Software reaches it through a small register window: every channel has a control word, a live memory address and a remaining byte count, and one shared byte holds a completion flag per channel. Software first loads a channel's address and count and then writes its control word. If the run bit is set in that word, the channel starts. It asks for the shared memory port whenever its endpoint is ready, and each granted word moves the address forward and lowers the count.

A channel stops by itself when its count runs out or when the memory port reports an error. At that point it raises its status flag. If the stop came from an error, it also records a bus-error flag inside its control word. Reading the live address at the end and subtracting the programmed start gives the number of bytes moved. A single interrupt line combines the status flags of the channels that have their interrupt enable set.

The memory side is a plain request/grant port. Each grant completes one word and may report an error. All channels share this port under a fixed priority. On the endpoint side, each channel has a ready input and a strobe output, and one data bus in each direction is shared by all channels.

Top module: `usb_dma_engine`

## Requirements
- R1: After reset, every register reads zero, `mem_req`, `ep_strobe` and `irq` are low, and a read of an address outside the window returns zero.
- R2: The status byte sits at 0x200. For channel n, the control word is at 0x204+16n, the address at 0x208+16n and the count at 0x20C+16n. The control word fields are: bit 0 run, bit 1 direction (1 = memory to endpoint), bit 2 multi-packet mode, bit 3 interrupt enable, bits 7:4 endpoint number, bit 8 bus-error flag and bits 10:9 burst type. All fields read back as written, except that a control write always clears bit 8.
- R3: A count write above 0x10000 is held at 0x10000. The count register reads back the bytes that are still remaining.
- R4: While running, the channel moves one word per grant, 4 bytes each and fewer for a final partial word. The address advances and the count drops by the same amount. `mem_we` is high for endpoint-to-memory transfers, `ep_wdata` carries `mem_rdata`, and `mem_wdata` carries `ep_rdata`.
- R5: In mode 0 (bit 2 = 0), a channel requests the port only in cycles where its `ep_ready` is high.
- R6: In mode 1, once a channel has moved its first word it keeps requesting without looking at `ep_ready` until the count is used up.
- R7: When the final word moves, the run bit clears and the channel's status bit sets.
- R8: A grant with `mem_err` high produces no strobe and changes neither the address nor the count. It clears the run bit, sets the bus-error flag (bit 8) and sets the status bit.
- R9: Writing a control word with the run bit clear stops the channel at once. No status bit is raised, and no further words move.
- R10: Reading the status byte clears it. A completion or error in the same cycle as the read stays set.
- R11: `irq` is high exactly when some status bit is set whose channel has interrupt enable set.
- R12: When several channels request the port, the lowest-numbered channel is served. Each grant moves exactly one word and pulses at most one strobe.
- R13: Starting a channel with a count of zero sets its status bit and clears the run bit without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the status byte when it addresses 0x200) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the address |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | 32 | Memory byte address of the current word |
| mem_wdata | output | 32 | Word written to memory |
| mem_gnt | input | 1 | Word completes in this cycle |
| mem_err | input | 1 | The granted word failed |
| mem_rdata | input | 32 | Word read from memory |
| ep_ready | input | 8 | Per-channel endpoint ready |
| ep_strobe | output | 8 | Per-channel word-moved pulse |
| ep_rdata | input | 32 | Word from the endpoint FIFO of the served channel |
| ep_wdata | output | 32 | Word to the endpoint FIFO of the served channel |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `mem_gnt` and `mem_err` are only meaningful while `mem_req` is high, and that software never writes a channel's registers while expecting a word for that channel to move in the same cycle. The bench models memory with continuous assignments, so that a grant and an error depend only on the current request and address. It drives register accesses one per cycle, between clock edges. It gates grants with a separate enable, so that several channels can be made to request at once without any register write coinciding with a transfer.

// File: rtl/usb_dma_pkg.sv
package usb_dma_pkg;

  localparam int CNT_W     = 17;
  localparam int MAX_BYTES = 32'h0001_0000;
  localparam int WORD_B    = 4;

  typedef struct packed {
    logic [1:0] burst;
    logic       bus_err;
    logic [3:0] ep_num;
    logic       irq_en;
    logic       multi;
    logic       to_ep;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [2:0] word_step(input logic [CNT_W-1:0] left);
    if (left >= CNT_W'(WORD_B)) return 3'(WORD_B);
    return left[2:0];
  endfunction

  function automatic logic [CNT_W-1:0] clip_count(input logic [31:0] req);
    if (req > 32'(MAX_BYTES)) return CNT_W'(MAX_BYTES);
    return req[CNT_W-1:0];
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [15:0] w);
    ctrl_t c;
    c = ctrl_t'(w[CTRL_W-1:0]);
    c.bus_err = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/usb_dma_arb.sv
module usb_dma_arb #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  pick,
  output logic [IW-1:0] pick_idx,
  output logic          any
);
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick     = '0;
        pick[i]  = 1'b1;
        pick_idx = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/usb_dma_chan.sv
module usb_dma_chan
  import usb_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_addr,
  input  logic             wr_cnt,
  input  logic [31:0]      wdata,
  input  logic             ep_ready,
  input  logic             gnt,
  input  logic             err,
  output logic             req,
  output ctrl_t            ctrl,
  output logic [AW-1:0]    addr,
  output logic [CNT_W-1:0] cnt,
  output logic             done_evt,
  output logic             err_evt
);
  logic       primed_q;
  logic       touched;
  logic       moved;
  logic [2:0] step;

  assign touched  = wr_ctrl | wr_addr | wr_cnt;
  assign step     = word_step(cnt);
  assign req      = ctrl.run && (cnt != '0) && !touched &&
                    (ep_ready || (ctrl.multi && primed_q));
  assign moved    = gnt && !err;
  assign err_evt  = !touched && gnt && err;
  assign done_evt = !touched && ctrl.run &&
                    ((moved && cnt == CNT_W'(step)) || cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      addr     <= '0;
      cnt      <= '0;
      primed_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl     <= ctrl_from_word(wdata[15:0]);
        primed_q <= 1'b0;
      end else begin
        if (err_evt) begin
          ctrl.bus_err <= 1'b1;
          ctrl.run     <= 1'b0;
        end else if (done_evt) begin
          ctrl.run <= 1'b0;
        end
        if (moved) primed_q <= 1'b1;
      end
      if (wr_addr)    addr <= wdata[AW-1:0];
      else if (moved) addr <= addr + AW'(step);
      if (wr_cnt)     cnt  <= clip_count(wdata);
      else if (moved) cnt  <= cnt - CNT_W'(step);
    end
  end
endmodule

// File: rtl/usb_dma_engine.sv
module usb_dma_engine
  import usb_dma_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int REG_AW  = 12,
  parameter int MEM_AW  = 32,
  parameter int WIN_BASE = 'h200,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WIN_END = WIN_BASE + NUM_CH * 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  input  logic [NUM_CH-1:0] ep_ready,
  output logic [NUM_CH-1:0] ep_strobe,
  input  logic [31:0]       ep_rdata,
  output logic [31:0]       ep_wdata,
  output logic              irq
);
  logic [REG_AW-1:0] rel;
  logic [CH_W-1:0]   sel_ch;
  logic [3:0]        sel_off;
  logic              in_win;
  logic              status_rd;

  ctrl_t              ch_ctrl [NUM_CH];
  logic [MEM_AW-1:0]  ch_addr [NUM_CH];
  logic [CNT_W-1:0]   ch_cnt  [NUM_CH];
  logic [NUM_CH-1:0]  ch_req, ch_run, ch_multi, ch_ie;
  logic [NUM_CH-1:0]  done_vec, err_vec, gnt_vec, pick;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [CH_W-1:0]    win_idx;
  logic [NUM_CH-1:0]  status_q;

  assign rel       = reg_addr - REG_AW'(WIN_BASE);
  assign sel_ch    = rel[CH_W+3:4];
  assign sel_off   = rel[3:0];
  assign in_win    = (int'(reg_addr) >= WIN_BASE) && (int'(reg_addr) < WIN_END);
  assign status_rd = reg_rd && (int'(reg_addr) == WIN_BASE);

  usb_dma_arb #(.N(NUM_CH)) u_arb (
    .req(ch_req), .pick(pick), .pick_idx(win_idx), .any(mem_req)
  );

  assign gnt_vec   = pick & {NUM_CH{mem_gnt}};
  assign ep_strobe = gnt_vec & {NUM_CH{!mem_err}};
  assign mem_addr  = ch_addr[win_idx];
  assign mem_we    = !ch_ctrl[win_idx].to_ep;
  assign mem_wdata = ep_rdata;
  assign ep_wdata  = mem_rdata;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic hit;
    assign hit = reg_wr && in_win && (sel_ch == CH_W'(n));
    usb_dma_chan #(.AW(MEM_AW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(hit && sel_off == 4'h4),
      .wr_addr(hit && sel_off == 4'h8),
      .wr_cnt (hit && sel_off == 4'hC),
      .wdata(reg_wdata),
      .ep_ready(ep_ready[n]),
      .gnt(gnt_vec[n]), .err(mem_err),
      .req(ch_req[n]),
      .ctrl(ch_ctrl[n]), .addr(ch_addr[n]), .cnt(ch_cnt[n]),
      .done_evt(done_vec[n]), .err_evt(err_vec[n])
    );
    assign ch_run[n]   = ch_ctrl[n].run;
    assign ch_multi[n] = ch_ctrl[n].multi;
    assign ch_ie[n]    = ch_ctrl[n].irq_en;
    assign cnt_flat[n*CNT_W +: CNT_W] = ch_cnt[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~{NUM_CH{status_rd}}) | done_vec | err_vec;
  end

  assign irq = |(status_q & ch_ie);

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == WIN_BASE) begin
      reg_rdata = 32'(status_q);
    end else if (in_win) begin
      case (sel_off)
        4'h4:    reg_rdata = 32'(ch_ctrl[sel_ch]);
        4'h8:    reg_rdata = 32'(ch_addr[sel_ch]);
        4'hC:    reg_rdata = 32'(ch_cnt[sel_ch]);
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_dma_engine_chk.sv
module usb_dma_engine_chk
  import usb_dma_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mem_req,
  input logic                    mem_gnt,
  input logic                    mem_err,
  input logic                    irq,
  input logic [NUM_CH-1:0]       ep_ready,
  input logic [NUM_CH-1:0]       ep_strobe,
  input logic [NUM_CH-1:0]       ch_req,
  input logic [NUM_CH-1:0]       ch_run,
  input logic [NUM_CH-1:0]       ch_multi,
  input logic [NUM_CH-1:0]       done_vec,
  input logic [NUM_CH-1:0]       err_vec,
  input logic [NUM_CH-1:0]       status_q,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  logic [NUM_CH-1:0] evt;
  assign evt = done_vec | err_vec;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_strobe)); // R12
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ep_strobe) |-> ((ch_req & (ep_strobe - 1'b1)) == '0)); // R12
  AST_STROBE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (|ep_strobe) |-> (mem_gnt && !mem_err)); // R8
  AST_REQ_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (|ch_run)); // R4
  AST_EVT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt))); // R10
  AST_EVT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((ch_run & $past(evt)) == '0)); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq); // R11

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    AST_MODE0_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_strobe[i] && !ch_multi[i]) |-> ep_ready[i]); // R5
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[i*CNT_W +: CNT_W] <= CNT_W'(MAX_BYTES)); // R3
  end
endmodule

bind usb_dma_engine usb_dma_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_err(mem_err), .irq(irq), .ep_ready(ep_ready), .ep_strobe(ep_strobe),
  .ch_req(ch_req), .ch_run(ch_run), .ch_multi(ch_multi),
  .done_vec(done_vec), .err_vec(err_vec), .status_q(status_q),
  .cnt_flat(cnt_flat)
);

// File: tb/usb_dma_engine_tb.sv
module usb_dma_engine_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  ep_ready = '0, ep_strobe;
  logic [31:0] ep_rdata = '0, ep_wdata;
  logic        irq;
  logic        gnt_en = 1;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  int checks = 0, errors = 0;
  int stb_cnt [8];
  int ord [8];
  int ord_n = 0;
  logic saw_req = 0;
  logic [31:0] last_epw, last_ma, last_mw;
  logic last_we;

  always #5 clk = ~clk;

  assign mem_gnt   = mem_req & gnt_en;
  assign mem_err   = mem_req && (mem_addr == err_addr);
  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

  usb_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .ep_ready(ep_ready), .ep_strobe(ep_strobe),
    .ep_rdata(ep_rdata), .ep_wdata(ep_wdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) saw_req = 1;
      for (int i = 0; i < 8; i++) begin
        if (ep_strobe[i]) begin
          stb_cnt[i]++;
          if (ord_n < 8) begin ord[ord_n] = i; ord_n++; end
          last_epw = ep_wdata; last_we = mem_we;
          last_ma = mem_addr; last_mw = mem_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int i = 0; i < 8; i++) stb_cnt[i] = 0;
    ord_n = 0; saw_req = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic [11:0] cb(input int n, input int off);
    return 12'('h200 + 16 * n + off);
  endfunction

  task automatic start(input int n, input logic [31:0] a, input logic [31:0] c, input logic [15:0] ctl);
    wr(cb(n, 8), a); wr(cb(n, 12), c); wr(cb(n, 4), 32'(ctl));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "mem_req", 32'(mem_req), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "strobe", 32'(ep_strobe), 0);
    rd(12'h200, d); chk("R1", "status", d, 0);
    rd(cb(3, 4), d); chk("R1", "ctrl3", d, 0);
    rd(cb(6, 12), d); chk("R1", "cnt6", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(cb(5, 12), 32'h0003_0000); rd(cb(5, 12), d); chk("R3", "count clip", d, 32'h0001_0000);
    wr(cb(5, 12), 32'h0000_1234); rd(cb(5, 12), d); chk("R3", "count plain", d, 32'h1234);
    wr(cb(5, 8), 32'hDEAD_BEEC); rd(cb(5, 8), d); chk("R2", "addr", d, 32'hDEAD_BEEC);
    wr(cb(5, 4), 32'h0000_07F6); rd(cb(5, 4), d); chk("R2", "ctrl fields", d, 32'h0000_06F6);
    rd(12'h300, d); chk("R1", "outside window", d, 0);
    wr(cb(5, 4), 0); wr(cb(5, 8), 0); wr(cb(5, 12), 0);
  endtask

  task automatic t_mode0_out();
    logic [31:0] d;
    clear_mon(); ep_ready[2] = 1;
    start(2, 32'h1000, 10, 16'h005B);
    idle(8);
    chk("R4", "words ch2", stb_cnt[2], 3);
    chk("R4", "last word data", last_epw, 32'hA5A5_1008);
    chk("R4", "read dir", 32'(last_we), 0);
    chk("R11", "irq on", 32'(irq), 1);
    rd(cb(2, 8), d);  chk("R4", "end addr", d, 32'h100A);
    rd(cb(2, 12), d); chk("R3", "remaining", d, 0);
    rd(cb(2, 4), d);  chk("R7", "run cleared", d, 32'h5A);
    rd(12'h200, d);   chk("R7", "status", d, 32'h04);
    rd(12'h200, d);   chk("R10", "status cleared", d, 0);
    chk("R11", "irq off", 32'(irq), 0);
    ep_ready[2] = 0;
  endtask

  task automatic t_mode0_pause();
    logic [31:0] d;
    clear_mon(); ep_rdata = 32'hC0DE_1234;
    start(1, 32'h2000, 8, 16'h0001);
    idle(5);
    chk("R5", "no words w/o ready", stb_cnt[1], 0);
    rd(cb(1, 12), d); chk("R5", "count held", d, 8);
    ep_ready[1] = 1;
    idle(6);
    chk("R5", "words after ready", stb_cnt[1], 2);
    chk("R4", "mem write addr", last_ma, 32'h2004);
    chk("R4", "mem write data", last_mw, 32'hC0DE_1234);
    chk("R4", "write dir", 32'(last_we), 1);
    chk("R11", "masked irq", 32'(irq), 0);
    rd(12'h200, d); chk("R7", "status ch1", d, 32'h02);
    ep_ready[1] = 0;
  endtask

  task automatic t_mode1();
    logic [31:0] d;
    clear_mon();
    start(3, 32'h4000, 16, 16'h000F);
    idle(3);
    chk("R6", "idle before ready", stb_cnt[3], 0);
    @(negedge clk); ep_ready[3] = 1;
    @(negedge clk); ep_ready[3] = 0;
    idle(8);
    chk("R6", "all words after one ready", stb_cnt[3], 4);
    rd(cb(3, 12), d); chk("R6", "remaining", d, 0);
    rd(12'h200, d);   chk("R7", "status ch3", d, 32'h08);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    clear_mon(); gnt_en = 0; ep_ready[4] = 1; ep_ready[5] = 1;
    start(5, 32'h5000, 8, 16'h0003);
    start(4, 32'h6000, 8, 16'h0003);
    @(negedge clk); gnt_en = 1;
    idle(8);
    chk("R12", "order n", ord_n, 4);
    chk("R12", "order0", ord[0], 4);
    chk("R12", "order1", ord[1], 4);
    chk("R12", "order2", ord[2], 5);
    chk("R12", "order3", ord[3], 5);
    rd(12'h200, d); chk("R7", "status ch4 ch5", d, 32'h30);
    ep_ready[4] = 0; ep_ready[5] = 0;
  endtask

  task automatic t_error();
    logic [31:0] d;
    clear_mon(); err_addr = 32'h3004; ep_ready[6] = 1;
    start(6, 32'h3000, 12, 16'h000B);
    idle(6);
    chk("R8", "one good word", stb_cnt[6], 1);
    rd(cb(6, 4), d);  chk("R8", "bus err flag", d, 32'h10A);
    rd(cb(6, 8), d);  chk("R8", "addr held", d, 32'h3004);
    rd(cb(6, 12), d); chk("R8", "count held", d, 8);
    chk("R11", "irq err", 32'(irq), 1);
    rd(12'h200, d);   chk("R8", "status ch6", d, 32'h40);
    wr(cb(6, 4), 32'h000A); rd(cb(6, 4), d); chk("R2", "write clears err flag", d, 32'h0A);
    err_addr = 32'hFFFF_FFFF; ep_ready[6] = 0;
  endtask

  task automatic t_abort();
    logic [31:0] d;
    clear_mon();
    start(7, 32'h7000, 16, 16'h000B);
    idle(2);
    wr(cb(7, 4), 0); wr(cb(7, 8), 0); wr(cb(7, 12), 0);
    ep_ready[7] = 1;
    idle(5);
    chk("R9", "no words after stop", stb_cnt[7], 0);
    rd(cb(7, 4), d); chk("R9", "ctrl zero", d, 0);
    rd(12'h200, d);  chk("R9", "no status", d, 0);
    ep_ready[7] = 0;
  endtask

  task automatic t_zero();
    logic [31:0] d;
    clear_mon(); ep_ready[0] = 1;
    start(0, 32'h8000, 0, 16'h0009);
    idle(4);
    chk("R13", "no request", 32'(saw_req), 0);
    rd(cb(0, 4), d); chk("R13", "run cleared", d, 32'h08);
    rd(12'h200, d);  chk("R13", "status ch0", d, 32'h01);
    ep_ready[0] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    t_reset();
    t_regs();
    t_mode0_out();
    t_mode0_pause();
    t_mode1();
    t_prio();
    t_error();
    t_abort();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule